// File: doc/BRIEF.md
# Eight-bit timer with double-buffered compare

This block is an 8-bit up-counter with a divider in front of it. A 3-bit clock-select field either stops the counter or advances it once every 1, 8, 64 or 256 system clocks. The count runs in one of three ways:

- It can run freely through 0x00..0xFF.
- It can restart from zero after it reaches the compare value.
- It can run freely while the compare value is double-buffered, which gives a single-slope PWM output.

Software uses a small write-only register port. Through it, software loads the compare buffer, sets the mode and the clock select, sets the two interrupt enables, and clears the two status flags. The block drives four outputs:

- the live count;
- a sticky compare flag and a sticky overflow flag;
- a single interrupt line, which is the flags gated by their enables;
- a waveform pin that follows compare matches.

The compare value is held twice. Software writes a buffer, and an active copy feeds the comparator. In the PWM mode the active copy is loaded only when the count leaves 0xFF, so a new duty value never splits a period.

Top module: `tmr8_top`

## Requirements
- R1: After reset the count is 0x00, both flags, `irq` and `wave` are 0, the mode is 0, the clock select is 0 (stopped), the compare buffer and the active compare value are 0x00, and both enables are 0.
- R2: The register at `wr_addr` 1 holds the clock select in bits [4:2]. Value 1 gives a tick every clock, 2 every 8 clocks, 3 every 64 clocks and 4 every 256 clocks. Values 0, 5, 6 and 7 give no ticks, and the count holds. When the selection changes, the divider restarts, and the first tick falls N clocks after the write that changed it.
- R3: The register at `wr_addr` 1 holds the mode in bits [1:0]: 0 is free-run, 1 is clear-on-compare, 2 is buffered PWM, and 3 behaves as 0. Outside mode 1, each tick adds one to the count, and 0xFF is followed by 0x00.
- R4: In mode 1, a tick that finds the count equal to the active compare value sets the count to 0x00. Other ticks add one.
- R5: A tick that finds the count equal to the active compare value sets `cmp_flag` on the following clock edge.
- R6: A tick that finds the count at 0xFF sets `ovf_flag` on the following clock edge.
- R7: A write to `wr_addr` 3 clears `cmp_flag` when bit 0 is 1 and clears `ovf_flag` when bit 1 is 1. A flag set in the same cycle stays set.
- R8: `irq` is high exactly when (`cmp_flag` and enable bit 0) or (`ovf_flag` and enable bit 1) holds. The enables are written at `wr_addr` 2.
- R9: A write to `wr_addr` 0 loads the compare buffer. In modes 0, 1 and 3 the active compare value takes the new value on the same edge. In mode 2 the active value is loaded from the buffer only on a tick that finds the count at 0xFF.
- R10: In modes 0, 1 and 3, `wave` toggles on every compare match. In mode 2, `wave` goes to 1 on a tick at 0xFF, and otherwise goes to 0 on a compare match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare, 1 control, 2 enables, 3 flag clear |
| wr_data | input | 8 | Write data |
| count | output | 8 | Current count value |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Masked interrupt request |
| wave | output | 1 | Waveform output |

## Verification
The hardest cases to reach from the ports are a flag-clear write that lands in the same cycle as a new match, and a compare write that lands in the middle of a PWM period.

The bench reaches the first case with a compare value of 1 at divide-by-1, so a match occurs every other clock, and then issues clear writes on consecutive cycles so that they repeatedly coincide with matches. It reaches the second case by rewriting the compare value partway through a PWM period, and by trying the extreme duty values 0x00 and 0xFF.

Changes of the divider selection are made both from the stopped state and in the middle of a divide interval.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CLR  = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_ALT  = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] A_CMP = 2'd0;
  localparam logic [1:0] A_CTL = 2'd1;
  localparam logic [1:0] A_MSK = 2'd2;
  localparam logic [1:0] A_FLG = 2'd3;

  // Divider exponent for a clock select code; -1 means stopped.
  function automatic int div_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/tmr_presc.sv
`timescale 1ns/1ps
module tmr_presc #(
  parameter int SEL_W = 3,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pc, pc_eff, mask;
  logic             active, sel_chg;
  int               sh;

  always_comb begin
    sh      = tmr_pkg::div_shift(3'(sel));
    active  = (sh >= 0);
    mask    = active ? PRE_W'((1 << sh) - 1) : '0;
    sel_chg = (sel != sel_q);
    pc_eff  = sel_chg ? '0 : pc;
    tick    = active && ((pc_eff & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      pc    <= '0;
    end else begin
      sel_q <= sel;
      pc    <= active ? pc_eff + 1'b1 : '0;
    end
  end

  AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_W'(1)) |-> tick);  // R2
  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> !tick);  // R2
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tmr_pkg::tmr_mode_e mode,
  input  logic [CNT_W-1:0] buf_nxt,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_act,
  output logic             match_evt,
  output logic             ovf_evt,
  output logic             wave
);
  import tmr_pkg::*;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic             at_max, hit, load_act, wave_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] c, input logic clr);
    return clr ? '0 : c + 1'b1;
  endfunction

  always_comb begin
    at_max    = (cnt == MAXV);
    hit       = (cnt == cmp_act);
    match_evt = tick & hit;
    ovf_evt   = tick & at_max;
    cnt_nxt   = tick ? step_count(cnt, (mode == MODE_CLR) && hit) : cnt;
    load_act  = (mode != MODE_PWM) || ovf_evt;
    if (mode == MODE_PWM)
      wave_nxt = ovf_evt ? 1'b1 : (match_evt ? 1'b0 : wave);
    else
      wave_nxt = wave ^ match_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmp_act <= '0;
      wave    <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      wave <= wave_nxt;
      if (load_act) cmp_act <= buf_nxt;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(mode == MODE_CLR && cnt == cmp_act)) |=> cnt == CNT_W'($past(cnt) + 1'b1));  // R3
  AST_CLR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLR && match_evt) |=> cnt == '0);  // R4
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM && !ovf_evt) |=> $stable(cmp_act));  // R9
  AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_PWM && match_evt) |=> wave != $past(wave));  // R10
  AST_PWM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM && ovf_evt) |=> wave);  // R10
endmodule

// File: rtl/tmr8_top.sv
`timescale 1ns/1ps
module tmr8_top #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2,
  parameter int SEL_W  = 3,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              cmp_flag,
  output logic              ovf_flag,
  output logic              irq,
  output logic              wave
);
  import tmr_pkg::*;
  localparam int SEL_LO = 2;
  localparam int SEL_HI = SEL_LO + SEL_W - 1;

  logic [CNT_W-1:0] cmp_buf, buf_nxt, cmp_act;
  tmr_mode_e        mode_r;
  logic [SEL_W-1:0] sel_r;
  logic [1:0]       msk_r;
  logic             tick, match_evt, ovf_evt;
  logic             wr_cmp, wr_ctl, wr_msk, wr_flg, clr_cf, clr_of;
  logic             unused_hi;

  assign unused_hi = ^wr_data[CNT_W-1:SEL_HI+1];

  always_comb begin
    wr_cmp  = wr_en && (wr_addr == ADDR_W'(A_CMP));
    wr_ctl  = wr_en && (wr_addr == ADDR_W'(A_CTL));
    wr_msk  = wr_en && (wr_addr == ADDR_W'(A_MSK));
    wr_flg  = wr_en && (wr_addr == ADDR_W'(A_FLG));
    clr_cf  = wr_flg && wr_data[0];
    clr_of  = wr_flg && wr_data[1];
    buf_nxt = wr_cmp ? wr_data : cmp_buf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf  <= '0;
      mode_r   <= MODE_FREE;
      sel_r    <= '0;
      msk_r    <= '0;
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      cmp_buf <= buf_nxt;
      if (wr_ctl) begin
        mode_r <= tmr_mode_e'(wr_data[1:0]);
        sel_r  <= wr_data[SEL_HI:SEL_LO];
      end
      if (wr_msk) msk_r <= wr_data[1:0];
      cmp_flag <= match_evt | (cmp_flag & ~clr_cf);
      ovf_flag <= ovf_evt   | (ovf_flag & ~clr_of);
    end
  end

  assign irq = (cmp_flag & msk_r[0]) | (ovf_flag & msk_r[1]);

  tmr_presc #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel(sel_r), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_r), .buf_nxt(buf_nxt),
    .cnt(count), .cmp_act(cmp_act), .match_evt(match_evt), .ovf_evt(ovf_evt),
    .wave(wave)
  );

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_r == '0) |=> $stable(count));  // R2
  AST_CMP_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> cmp_flag);  // R5
  AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);  // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cf && !match_evt) |=> !cmp_flag);  // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_flag && !ovf_flag) |-> !irq);  // R8
endmodule

// File: tb/tmr8_top_tb.sv
`timescale 1ns/1ps
module tmr8_top_tb;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic       cmp_flag, ovf_flag, irq, wave;

  always #2.5 clk = ~clk;

  tmr8_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .irq(irq), .wave(wave)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_cnt, m_mode, m_sel, m_selq, m_phase, m_buf, m_act, m_cf, m_of, m_msk, m_wave;

  function automatic int period(int s);
    case (s)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int per, tk, hit, ovf, nb, ncnt, nw;
    per = period(m_sel);
    if (m_sel != m_selq) m_phase = 0;
    tk = (per != 0) && ((m_phase % per) == per - 1);
    m_phase++;
    hit  = tk && (m_cnt == m_act);
    ovf  = tk && (m_cnt == 255);
    ncnt = m_cnt;
    if (tk) ncnt = (m_mode == 1 && m_cnt == m_act) ? 0 : (m_cnt + 1) % 256;
    nw = m_wave;
    if (m_mode == 2) begin
      if (ovf) nw = 1; else if (hit) nw = 0;
    end else if (hit) nw = 1 - m_wave;
    nb = m_buf;
    if (wr_en && wr_addr == 0) nb = wr_data;
    if (m_mode != 2 || ovf) m_act = nb;
    m_buf = nb;
    if (wr_en && wr_addr == 3 && wr_data[0]) m_cf = 0;
    if (wr_en && wr_addr == 3 && wr_data[1]) m_of = 0;
    if (hit) m_cf = 1;
    if (ovf) m_of = 1;
    m_selq = m_sel;
    if (wr_en && wr_addr == 1) begin
      m_mode = wr_data[1:0];
      m_sel  = wr_data[4:2];
    end
    if (wr_en && wr_addr == 2) m_msk = wr_data[1:0];
    m_cnt  = ncnt;
    m_wave = nw;
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 count", count, m_cnt);
    chk("R5 R7 cmp_flag", cmp_flag, m_cf);
    chk("R6 R7 ovf_flag", ovf_flag, m_of);
    chk("R8 irq", irq, ((m_cf != 0) && (m_msk & 1)) || ((m_of != 0) && (m_msk & 2)));
    chk("R9 R10 wave", wave, m_wave);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    m_cnt = 0; m_mode = 0; m_sel = 0; m_selq = 0; m_phase = 0; m_buf = 0;
    m_act = 0; m_cf = 0; m_of = 0; m_msk = 0; m_wave = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 count", count, 0);
    chk("R1 cmp_flag", cmp_flag, 0);
    chk("R1 ovf_flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wave", wave, 0);
    run(5);
    chk("R1 stopped count", count, 0);

    wr(2, 3);
    wr(0, 5);
    wr(1, (1 << 2) | 0);
    run(300);

    // R2: divide-by-8 restart after a selection change
    wr(1, (2 << 2) | 0);
    c = count;
    for (int i = 0; i < 7; i++) begin
      cyc();
      chk("R2 hold before 8th clock", count, c);
    end
    cyc();
    chk("R2 tick on 8th clock", count, (c + 1) % 256);
    run(200);
    wr(1, 3 << 2);
    run(300);
    wr(1, 4 << 2);
    run(1100);

    wr(1, 0);
    run(20);
    wr(3, 3);
    chk("R7 cmp_flag cleared", cmp_flag, 0);
    chk("R7 ovf_flag cleared", ovf_flag, 0);
    wr(1, 6 << 2);
    run(20);

    // R8: masked flags raise no request
    wr(2, 0);
    wr(1, 1 << 2);
    run(300);
    chk("R8 flags set", cmp_flag & ovf_flag, 1);
    chk("R8 irq masked", irq, 0);
    wr(2, 3);
    run(5);

    // R4: clear-on-compare
    wr(0, 10);
    wr(1, (1 << 2) | 1);
    run(60);
    wr(0, 3);
    run(30);

    // R7: clear writes racing matches
    wr(0, 1);
    run(4);
    for (int i = 0; i < 40; i++) wr(3, (i % 3) + 1);
    run(4);

    // R9 R10: buffered PWM
    wr(0, 100);
    wr(1, (1 << 2) | 2);
    run(300);
    wr(0, 30);
    run(400);
    wr(0, 255);
    run(300);
    wr(0, 0);
    run(300);

    // R3: mode 3 behaves as free-run
    wr(1, (1 << 2) | 3);
    run(300);

    // R2: selection change in the middle of an interval
    wr(1, 2 << 2);
    run(5);
    wr(1, 3 << 2);
    run(70);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule